// File: doc/BRIEF.md
# Four-Pin Blinking GPIO Bank with Change Faults

This block manages four general-purpose pins. Each pin works either as a digital input or as an open-drain pull-down output. An output pin can hold a steady level or blink at a rate set by a shared slow tick. All configuration comes from single-cycle register writes issued by a serial interface controller. That controller is outside the block, and so is the pad itself: the block only produces a pull-down enable for each pin and receives the raw pad level for each pin.

Any pin can be armed so that a change in its sampled level sets a sticky status bit. That bit stays set until software writes a 1 to it or the block is reset. The OR of all status bits drives a single fault line toward a shared fault combiner.

Pad levels are resynchronised before use. Change detection works in every mode, including on an output pin whose pull-down is released.

Top module: `gpio_blink_fault`

## Requirements
- R1: After reset every pin is an input, nothing is pulled down, fault enables and status are zero, and `faultOut` is low.
- R2: Register 0 (mode) sets the pin direction: bit i = 1 makes pin i an output. Register 1 (drive) sets the output level: bit i = 1 pulls pin i low. An output pin without blink asserts `padPullDown[i]` equal to its drive bit. An input pin never asserts its pull-down.
- R3: Register 2 (blink) bit i = 1 on an output pin makes its pull-down follow a shared phase bit. The phase inverts at each clock edge where `blinkTick` is high, so with a regular tick the pull-down has a 50% duty cycle.
- R4: A read at address 5 returns the synchronised pad levels. A pad change first appears there after the second rising clock edge.
- R5: Register 3 (fault enable) bit i = 1 arms pin i. A change in its sampled level sets bit i of register 4 (fault status), and the bit is visible after the third rising edge following the pad change.
- R6: A set status bit stays set while its pin is idle or changes again, until it is cleared.
- R7: Writing register 4 clears exactly the status bits written as 1 and leaves the others unchanged.
- R8: When a change sets a status bit on the same edge as a write that clears it, the bit ends up set.
- R9: A pin whose fault enable bit is 0 never sets its status bit.
- R10: An output pin with its pull-down released still detects changes on its pad.
- R11: `faultOut` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle |
| wrAddr | input | 3 | Write address (0 mode, 1 drive, 2 blink, 3 fault enable, 4 fault status) |
| wrData | input | 4 | Write data, one bit per pin |
| rdAddr | input | 3 | Read address (0 to 4 as for writes, 5 pad levels; other addresses read 0) |
| rdData | output | 4 | Read data, combinational from `rdAddr` |
| blinkTick | input | 1 | Shared slow tick, one cycle wide |
| padIn | input | 4 | Raw pad levels |
| padPullDown | output | 4 | Pull-down enable for each pad |
| faultOut | output | 1 | OR of all fault status bits |

## Verification
A wrong mode, drive or blink register shows on `padPullDown` in the cycle after the write. A wrong blink phase shows after the next tick. A fault in the synchroniser or in the previous-sample register shifts or drops a status bit: this is visible at `faultOut` and on a read of address 4 within three edges of a pad change. A wrong clear mask shows on the first read after the write. Because the reference model is compared on every clock, any of these errors is reported in the first cycle where an output differs.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE       = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DRIVE      = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_BLINK      = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FAULT_EN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_FAULT_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_PAD        = 3'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldMode;
    logic ldDrive;
    logic ldBlink;
    logic ldFaultEn;
    logic clrFault;
    logic blinkPhase;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              blinkTick,
  output ctrlStrobes_t      strobes
);
  logic phaseQ;

  // One phase shared by all blinking pins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseQ <= 1'b0;
    end else if (blinkTick) begin
      phaseQ <= ~phaseQ;
    end
  end

  always_comb begin
    strobes.ldMode     = wrEn && (wrAddr == ADDR_MODE);
    strobes.ldDrive    = wrEn && (wrAddr == ADDR_DRIVE);
    strobes.ldBlink    = wrEn && (wrAddr == ADDR_BLINK);
    strobes.ldFaultEn  = wrEn && (wrAddr == ADDR_FAULT_EN);
    strobes.clrFault   = wrEn && (wrAddr == ADDR_FAULT_STAT);
    strobes.blinkPhase = phaseQ;
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padPullDown,
  output logic                faultOut,
  output logic [NUM_PINS-1:0] modeBits,
  output logic [NUM_PINS-1:0] blinkBits,
  output logic [NUM_PINS-1:0] fenBits,
  output logic [NUM_PINS-1:0] statBits
);
  localparam int unsigned VALID_LEN = SYNC_STAGES + 1;

  logic [NUM_PINS-1:0] modeQ, driveQ, blinkQ, fenQ, statQ, prevQ;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [VALID_LEN-1:0] validQ;
  logic [NUM_PINS-1:0] sample, changeMask, setMask, clrMask;
  logic primed;

  // Input synchroniser chain
  always_ff @(posedge clk) begin
    if (!rst_n) syncQ[0] <= '0;
    else        syncQ[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) syncQ[s] <= '0;
      else        syncQ[s] <= syncQ[s-1];
    end
  end

  assign sample = syncQ[SYNC_STAGES-1];
  assign primed = validQ[VALID_LEN-1];

  // Compare only once the previous sample holds a real pad value
  always_comb begin
    changeMask = primed ? (sample ^ prevQ) : '0;
    setMask    = changeMask & fenQ;
    clrMask    = strobes.clrFault ? wrData : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ  <= '0;
      driveQ <= '0;
      blinkQ <= '0;
      fenQ   <= '0;
      statQ  <= '0;
      prevQ  <= '0;
      validQ <= '0;
    end else begin
      if (strobes.ldMode)    modeQ  <= wrData;
      if (strobes.ldDrive)   driveQ <= wrData;
      if (strobes.ldBlink)   blinkQ <= wrData;
      if (strobes.ldFaultEn) fenQ   <= wrData;
      statQ  <= (statQ & ~clrMask) | setMask;
      prevQ  <= sample;
      validQ <= {validQ[VALID_LEN-2:0], 1'b1};
    end
  end

  // Pad control for each pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign padPullDown[p] = modeQ[p] & (blinkQ[p] ? strobes.blinkPhase : driveQ[p]);
  end

  assign faultOut = |statQ;

  always_comb begin
    case (rdAddr)
      ADDR_MODE:       rdData = modeQ;
      ADDR_DRIVE:      rdData = driveQ;
      ADDR_BLINK:      rdData = blinkQ;
      ADDR_FAULT_EN:   rdData = fenQ;
      ADDR_FAULT_STAT: rdData = statQ;
      ADDR_PAD:        rdData = sample;
      default:         rdData = '0;
    endcase
  end

  assign modeBits  = modeQ;
  assign blinkBits = blinkQ;
  assign fenBits   = fenQ;
  assign statBits  = statQ;
endmodule

// File: rtl/gpio_blink_fault.sv
module gpio_blink_fault
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [NUM_PINS-1:0] rdData,
  input  logic                blinkTick,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padPullDown,
  output logic                faultOut
);
  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] modeBits, blinkBits, fenBits, statBits;

  gpio_bank_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .blinkTick (blinkTick),
    .strobes   (strobes)
  );

  gpio_bank_dp #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .padIn       (padIn),
    .padPullDown (padPullDown),
    .faultOut    (faultOut),
    .modeBits    (modeBits),
    .blinkBits   (blinkBits),
    .fenBits     (fenBits),
    .statBits    (statBits)
  );
endmodule

// File: rtl/gpio_blink_fault_chk.sv
module gpio_blink_fault_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [NUM_PINS-1:0] wrData,
  input logic                blinkTick,
  input logic [NUM_PINS-1:0] padPullDown,
  input logic [NUM_PINS-1:0] modeBits,
  input logic [NUM_PINS-1:0] blinkBits,
  input logic [NUM_PINS-1:0] fenBits,
  input logic [NUM_PINS-1:0] statBits
);
  logic [NUM_PINS-1:0] keepBits;
  assign keepBits = statBits & ~((wrEn && wrAddr == ADDR_FAULT_STAT) ? wrData : '0);

  // R2: an input pin never pulls its pad
  p_input_never_pulls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (padPullDown & ~modeBits) == '0);

  // R2: without a write or tick the pad controls hold
  p_pull_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn && !blinkTick) |=> $stable(padPullDown));

  // R3: a tick inverts exactly the blinking output pins
  p_blink_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (blinkTick && !wrEn) |=> ((padPullDown ^ $past(padPullDown)) == $past(modeBits & blinkBits)));

  // R6: a status bit not being cleared stays set
  p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statBits & $past(keepBits)) == $past(keepBits)));

  // R9: new status bits appear only on armed pins
  p_fault_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((statBits & ~$past(statBits) & ~$past(fenBits)) == '0));
endmodule

bind gpio_blink_fault gpio_blink_fault_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .blinkTick   (blinkTick),
  .padPullDown (padPullDown),
  .modeBits    (modeBits),
  .blinkBits   (blinkBits),
  .fenBits     (fenBits),
  .statBits    (statBits)
);

// File: tb/gpio_blink_fault_tb.sv
`timescale 1ns/1ps
module gpio_blink_fault_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [N-1:0] wrData = '0;
  logic [2:0]   rdAddr = '0;
  logic [N-1:0] rdData;
  logic         blinkTick = 1'b0;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padPullDown;
  logic         faultOut;

  int errors = 0;
  int checks = 0;
  int tickCnt = 0;
  bit started = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_blink_fault u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .blinkTick(blinkTick), .padIn(padIn),
    .padPullDown(padPullDown), .faultOut(faultOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Shared slow tick, one cycle in eight
  always @(negedge clk) begin
    tickCnt = tickCnt + 1;
    blinkTick = (tickCnt % 8 == 0);
  end

  // Behavioural reference model
  logic [N-1:0] mMode, mDrive, mBlink, mFen, mStat;
  logic         mPhase;
  logic [N-1:0] hist [$];

  function automatic logic [N-1:0] modelPull();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      if (!mMode[i])      v[i] = 1'b0;
      else if (mBlink[i]) v[i] = mPhase;
      else                v[i] = mDrive[i];
    end
    return v;
  endfunction

  function automatic logic [N-1:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mMode;
      3'd1: return mDrive;
      3'd2: return mBlink;
      3'd3: return mFen;
      3'd4: return mStat;
      3'd5: return (hist.size() >= 2) ? hist[hist.size()-2] : '0;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mMode = '0; mDrive = '0; mBlink = '0; mFen = '0; mStat = '0; mPhase = 1'b0;
      hist.delete();
    end else begin
      logic [N-1:0] clr, set;
      clr = (wrEn && wrAddr == 3'd4) ? wrData : '0;
      set = '0;
      if (hist.size() >= 3) set = (hist[hist.size()-2] ^ hist[hist.size()-3]) & mFen;
      mStat = (mStat & ~clr) | set;
      if (wrEn) begin
        case (wrAddr)
          3'd0: mMode  = wrData;
          3'd1: mDrive = wrData;
          3'd2: mBlink = wrData;
          3'd3: mFen   = wrData;
          default: ;
        endcase
      end
      if (blinkTick) mPhase = ~mPhase;
      hist.push_back(padIn);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  // Compare against the model every clock, away from the edges
  always @(negedge clk) begin
    #1;
    if (started && !done) begin
      check("R2 model pull-down", 32'(padPullDown), 32'(modelPull()));
      check("R11 model fault line", 32'(faultOut), 32'(mStat != 0));
      check("R4 model read data", 32'(rdData), 32'(modelRead(rdAddr)));
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [N-1:0] d);
    rdAddr = a;
    #0.2;
    d = rdData;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] v;
    int hi0, hi1;
    step(4);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 pull-down after reset", 32'(padPullDown), 32'h0);
    check("R1 fault line after reset", 32'(faultOut), 32'h0);
    rdReg(3'd0, v); check("R1 mode after reset", 32'(v), 32'h0);
    rdReg(3'd3, v); check("R1 fault enable after reset", 32'(v), 32'h0);

    // R2 steady output and ignored drive on inputs
    wrReg(3'd0, 4'b0011);
    wrReg(3'd1, 4'b1101);
    check("R2 drive on outputs only", 32'(padPullDown), 32'h1);

    // R3 blink duty cycle on pin 1, pin 0 steady
    wrReg(3'd2, 4'b0010);
    hi0 = 0; hi1 = 0;
    for (int c = 0; c < 32; c++) begin
      step(1);
      hi0 += padPullDown[0];
      hi1 += padPullDown[1];
    end
    check("R3 blink high cycles of 32", 32'(hi1), 32'd16);
    check("R2 steady pin stays pulled", 32'(hi0), 32'd32);
    wrReg(3'd2, 4'b0000);
    wrReg(3'd1, 4'b0000);
    check("R2 released outputs", 32'(padPullDown), 32'h0);

    // R4 pad readback latency
    @(negedge clk); padIn = 4'b0101;
    step(1); rdReg(3'd5, v); check("R4 pad after one edge", 32'(v), 32'h0);
    step(1); rdReg(3'd5, v); check("R4 pad after two edges", 32'(v), 32'h5);

    // R9 no fault while disarmed
    step(3);
    rdReg(3'd4, v); check("R9 status while disarmed", 32'(v), 32'h0);
    check("R9 fault line while disarmed", 32'(faultOut), 32'h0);

    // R5 armed change
    wrReg(3'd3, 4'b1111);
    step(2);
    @(negedge clk); padIn = 4'b0001;
    step(2); check("R5 fault line before third edge", 32'(faultOut), 32'h0);
    step(1); check("R5 fault line after third edge", 32'(faultOut), 32'h1);
    rdReg(3'd4, v); check("R5 status bit 2", 32'(v), 32'h4);

    // R6 sticky across a further change and idle time
    @(negedge clk); padIn = 4'b0101;
    step(6);
    rdReg(3'd4, v); check("R6 status held", 32'(v), 32'h4);

    // R10 released output pin 0 detects its pad falling
    @(negedge clk); padIn = 4'b0100;
    step(3);
    rdReg(3'd4, v); check("R10 output pin change", 32'(v), 32'h5);

    // R7 per-bit clear, R11 fault line
    wrReg(3'd4, 4'b0001);
    rdReg(3'd4, v); check("R7 clear only bit 0", 32'(v), 32'h4);
    check("R11 fault line with one bit", 32'(faultOut), 32'h1);
    wrReg(3'd4, 4'b0100);
    rdReg(3'd4, v); check("R7 clear bit 2", 32'(v), 32'h0);
    check("R11 fault line all clear", 32'(faultOut), 32'h0);

    // R8 set on the same edge as clear
    @(negedge clk); padIn = 4'b0000;
    step(4);
    rdReg(3'd4, v); check("R8 precondition bit 2 set", 32'(v), 32'h4);
    @(negedge clk); padIn = 4'b0100;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; wrAddr = 3'd4; wrData = 4'b0100;
    @(negedge clk); wrEn = 1'b0;
    rdReg(3'd4, v); check("R8 set wins over clear", 32'(v), 32'h4);
    step(2);
    wrReg(3'd4, 4'b1111);
    rdReg(3'd4, v); check("R7 final clear", 32'(v), 32'h0);

    step(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule